// File: doc/BRIEF.md
# Program memory loader with read-back verification

This block loads the program memory of an embedded controller over a single-outstanding register transaction port and then checks that the memory holds what was sent. After a `start` pulse it halts the controller, rewinds the memory pointer, and writes every image byte in order. It then rewinds the pointer again, reads every byte back and compares each one with the image. Only if every byte matches does it release the controller. The memory side advances its own pointer on every data access, so the block never sends a per-byte address.

The image comes from a local byte-wide ROM port. The block drives `img_addr` and expects the matching byte on `img_data` in the same cycle. The image length is latched at `start`. Transactions go to an external register-access engine through a request/response pair: a request is offered until it is accepted, and the next request is not offered until the response arrives. When the sequence ends, `done` or `error` stays up with an error cause and a mismatch count until the next `start`.

States: ST_IDLE, ST_HALT (stop word to control), ST_PTR_UP (pointer rewind before upload), ST_LOAD (byte writes), ST_PTR_CHK (pointer rewind before verify), ST_CHECK (byte reads), ST_RUN (start word to control), ST_DONE and ST_FAIL. Transitions:
- launch: ST_IDLE, ST_DONE or ST_FAIL to ST_HALT on `start`.
- halt_ok: ST_HALT to ST_PTR_UP.
- rewind_ok: ST_PTR_UP to ST_LOAD, or to ST_PTR_CHK when the length is zero.
- load_last: ST_LOAD to ST_PTR_CHK.
- rewind2_ok: ST_PTR_CHK to ST_CHECK, or to ST_RUN when the length is zero.
- check_pass: ST_CHECK to ST_RUN.
- run_ok: ST_RUN to ST_DONE.
- abort: any command state to ST_FAIL on a transport error, a range failure, the mismatch limit being reached, or a final mismatch count above zero.

Top module: `ucode_loader`

## Requirements
- R1: The first transaction after `start` is a write to the control register (`req_reg` = 0) with the halt word 0x0000008C, which has bits 7, 3 and 2 set.
- R2: The pointer register (`req_reg` = 1) is written with 0 right after the halt write and again right after the last upload write, before any read.
- R3: The upload pass issues exactly `img_len` writes to the data register (`req_reg` = 2). Write k carries image byte k (the value on `img_data` while `img_addr` = k) zero-extended to 32 bits.
- R4: The verify pass issues one read (`req_write` = 0) of the data register per byte, in order, and compares response bits 7:0 with image byte k. Any nonzero bit 31:8 is handled by R5 instead.
- R5: A read response with any of bits 31:8 set ends the sequence at once with `error` = 1 and `err_code` = 2, and no further transaction is issued.
- R6: Each mismatching byte increments `mism_cnt` by one. When the count reaches 5, verification stops at once. A nonzero count at the end of verification gives `error` = 1 and `err_code` = 3, and the start word is never written.
- R7: When every byte matches, the control register is written with the run word 0x0000010B (bits 8, 3, 1, 0). After its response, `done` = 1, `error` = 0 and `err_code` = 0.
- R8: A response with `rsp_err` = 1 ends the sequence with `error` = 1 and `err_code` = 1, and no further transaction is issued.
- R9: `req_valid` stays high with `req_reg`, `req_write` and `req_wdata` stable until `req_ready`. No new request is offered until the response to the accepted one has arrived.
- R10: `busy` is high from the cycle after `start` until `done` or `error` rises. `done`, `error`, `err_code` and `mism_cnt` hold until the next `start`. A `start` pulse while busy is ignored.
- R11: After reset, `busy`, `done`, `error`, `err_code`, `mism_cnt` and `req_valid` are all 0.
- R12: With `img_len` = 0, the sequence is halt write, two pointer writes, then the run write, and it ends with `done` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load when not busy |
| img_len | input | LEN_W | Image length in bytes, latched at start |
| img_addr | output | LEN_W | Image byte index |
| img_data | input | 8 | Image byte at img_addr |
| req_valid | output | 1 | Transaction request offered |
| req_ready | input | 1 | Engine accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_reg | output | 2 | Target: 0 control, 1 pointer, 2 data |
| req_wdata | output | 32 | Write value |
| rsp_valid | input | 1 | Response for the accepted request |
| rsp_err | input | 1 | Transaction failed |
| rsp_rdata | input | 32 | Read value |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished cleanly |
| error | output | 1 | Sequence aborted |
| err_code | output | 2 | 0 none, 1 transport, 2 range, 3 verify |
| mism_cnt | output | MCNT_W | Mismatching bytes seen |

## Verification
The hardest case to reach from the ports is a verify pass that stops early on the fifth mismatch while later bytes are still unread, or a range failure that arrives with mismatches already counted. The bench gets there with a memory model inside its engine. That model flips the read-back of chosen byte positions or sets a high bit on one of them, and it can also fail any chosen transaction number. Seeded random image lengths and fault patterns are mixed with directed runs that place the fifth mismatch, the range fault and the transport faults at chosen positions. Every run's transaction log is compared entry by entry with a sequence the bench derives on its own.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
    localparam int WORD_W = 32;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_PTR  = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam logic [WORD_W-1:0] HALT_WORD = 32'h0000_008C;
    localparam logic [WORD_W-1:0] RUN_WORD  = 32'h0000_010B;

    localparam logic [1:0] ERR_NONE   = 2'd0;
    localparam logic [1:0] ERR_XPORT  = 2'd1;
    localparam logic [1:0] ERR_RANGE  = 2'd2;
    localparam logic [1:0] ERR_VERIFY = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_PTR_UP,
        ST_LOAD,
        ST_PTR_CHK,
        ST_CHECK,
        ST_RUN,
        ST_DONE,
        ST_FAIL
    } ucl_state_e;
endpackage

// File: rtl/ucl_xact.sv
// Tracks the single outstanding transaction: offer, acceptance, response.
module ucl_xact (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic req_valid,
    output logic rsp_take
);
    logic issued_q;

    assign req_valid = want && !issued_q;
    assign rsp_take  = issued_q && rsp_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            issued_q <= 1'b0;
        else if (req_valid && req_ready)
            issued_q <= 1'b1;
        else if (rsp_take)
            issued_q <= 1'b0;
    end
endmodule

// File: rtl/ucl_index.sv
// Byte index shared by the upload and verify passes.
module ucl_index #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] idx,
    output logic             last
);
    logic [LEN_W-1:0] idx_q;

    assign idx  = idx_q;
    assign last = (idx_q == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (clear)
            idx_q <= '0;
        else if (step)
            idx_q <= idx_q + 1'b1;
    end
endmodule

// File: rtl/ucl_mismatch.sv
// Mismatch counter; flags the hit that takes it past the tolerance.
module ucl_mismatch #(
    parameter int LIMIT = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hit,
    output logic [CNT_W-1:0] count,
    output logic             over
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    assign count = cnt_q;
    assign over  = hit && (cnt_q == LIM_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (hit)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
    import ucl_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int MISM_LIMIT = 4,
    parameter int MCNT_W     = $clog2(MISM_LIMIT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  img_len,
    output logic [LEN_W-1:0]  img_addr,
    input  logic [7:0]        img_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [1:0]        req_reg,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [31:0]       rsp_rdata,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code,
    output logic [MCNT_W-1:0] mism_cnt
);
    ucl_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [1:0]       err_q, err_d;
    logic             want, rsp_take, rsp_ok, rsp_bad;
    logic             launch, range_bad, byte_diff, hit, over, last, len_zero;
    logic             idx_clear, idx_step;

    assign launch    = start && (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);
    assign rsp_ok    = rsp_take && !rsp_err;
    assign rsp_bad   = rsp_take && rsp_err;
    assign range_bad = |rsp_rdata[WORD_W-1:8];
    assign byte_diff = (rsp_rdata[7:0] != img_data);
    assign hit       = rsp_ok && (state_q == ST_CHECK) && !range_bad && byte_diff;
    assign len_zero  = (len_q == '0);
    assign idx_clear = (state_q == ST_PTR_UP) || (state_q == ST_PTR_CHK);
    assign idx_step  = rsp_ok && ((state_q == ST_LOAD) || (state_q == ST_CHECK));

    ucl_xact u_xact (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .req_valid (req_valid),
        .rsp_take  (rsp_take)
    );

    ucl_index #(.LEN_W(LEN_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idx_clear),
        .step  (idx_step),
        .len   (len_q),
        .idx   (img_addr),
        .last  (last)
    );

    ucl_mismatch #(.LIMIT(MISM_LIMIT), .CNT_W(MCNT_W)) u_mism (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .hit   (hit),
        .count (mism_cnt),
        .over  (over)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            if (launch) begin
                len_q <= img_len;
                err_q <= ERR_NONE;
            end else if (state_d == ST_FAIL && state_q != ST_FAIL) begin
                err_q <= err_d;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        err_d   = ERR_NONE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (rsp_ok) state_d = ST_PTR_UP;
            end
            ST_PTR_UP: begin
                if (rsp_ok) state_d = len_zero ? ST_PTR_CHK : ST_LOAD;
            end
            ST_LOAD: begin
                if (rsp_ok && last) state_d = ST_PTR_CHK;
            end
            ST_PTR_CHK: begin
                if (rsp_ok) state_d = len_zero ? ST_RUN : ST_CHECK;
            end
            ST_CHECK: begin
                if (rsp_ok) begin
                    if (range_bad) begin
                        state_d = ST_FAIL;
                        err_d   = ERR_RANGE;
                    end else if (over) begin
                        state_d = ST_FAIL;
                        err_d   = ERR_VERIFY;
                    end else if (last) begin
                        if (hit || mism_cnt != '0) begin
                            state_d = ST_FAIL;
                            err_d   = ERR_VERIFY;
                        end else begin
                            state_d = ST_RUN;
                        end
                    end
                end
            end
            ST_RUN: begin
                if (rsp_ok) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (rsp_bad) begin
            state_d = ST_FAIL;
            err_d   = ERR_XPORT;
        end
    end

    // Outputs
    always_comb begin
        want      = 1'b0;
        req_write = 1'b1;
        req_reg   = REG_CTRL;
        req_wdata = '0;
        unique case (state_q)
            ST_HALT: begin
                want      = 1'b1;
                req_wdata = HALT_WORD;
            end
            ST_PTR_UP, ST_PTR_CHK: begin
                want    = 1'b1;
                req_reg = REG_PTR;
            end
            ST_LOAD: begin
                want      = 1'b1;
                req_reg   = REG_DATA;
                req_wdata = {{(WORD_W-8){1'b0}}, img_data};
            end
            ST_CHECK: begin
                want      = 1'b1;
                req_write = 1'b0;
                req_reg   = REG_DATA;
            end
            ST_RUN: begin
                want      = 1'b1;
                req_wdata = RUN_WORD;
            end
            default: ;
        endcase
    end

    assign busy     = !(state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);
    assign done     = (state_q == ST_DONE);
    assign error    = (state_q == ST_FAIL);
    assign err_code = err_q;
endmodule

// File: rtl/ucode_loader_chk.sv
module ucode_loader_chk
    import ucl_pkg::*;
#(
    parameter int MISM_LIMIT = 4,
    parameter int MCNT_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [1:0]        req_reg,
    input logic [31:0]       req_wdata,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [1:0]        err_code,
    input logic [MCNT_W-1:0] mism_cnt
);
    localparam logic [MCNT_W-1:0] CAP = MCNT_W'(MISM_LIMIT + 1);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_reg)
                                       && $stable(req_write) && $stable(req_wdata)));

    assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !error));

    assert_done_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code != ERR_NONE));

    assert_no_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !error |-> (err_code == ERR_NONE));

    assert_mism_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mism_cnt <= CAP);

    assert_mism_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (mism_cnt == $past(mism_cnt) || mism_cnt == $past(mism_cnt) + 1'b1));

    assert_run_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_reg == REG_CTRL && req_wdata == RUN_WORD)
            |-> (mism_cnt == '0));
endmodule

bind ucode_loader ucode_loader_chk #(.MISM_LIMIT(MISM_LIMIT), .MCNT_W(MCNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .err_code  (err_code),
    .mism_cnt  (mism_cnt)
);

// File: tb/ucode_loader_test.sv
`timescale 1ns/1ps
module ucode_loader_test;
    localparam int LEN_W  = 12;
    localparam int MAXN   = 64;
    localparam int MAXLOG = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [LEN_W-1:0] img_len = '0;
    logic [LEN_W-1:0] img_addr;
    logic [7:0]  img_data;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [1:0]  req_reg;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic        busy, done, error;
    logic [1:0]  err_code;
    logic [2:0]  mism_cnt;

    always #2.5 clk = ~clk;

    ucode_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
        .img_addr(img_addr), .img_data(img_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .busy(busy), .done(done), .error(error), .err_code(err_code),
        .mism_cnt(mism_cnt)
    );

    logic [7:0]  rom [MAXN];
    logic [7:0]  sram [MAXN];
    logic        corrupt [MAXN];
    int          range_idx, terr_txn;
    logic [1:0]  log_reg [MAXLOG];
    logic        log_wr  [MAXLOG];
    logic [31:0] log_wd  [MAXLOG];
    int          nlog, ptr, wait_cnt;
    bit          pend;
    int          n_checks = 0, n_fail = 0;
    int          cyc = 0;

    always_comb img_data = (img_addr < LEN_W'(MAXN)) ? rom[img_addr[5:0]] : 8'h00;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Register engine and target memory model
    initial begin
        pend = 0;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                pend      = 0;
            end else if (req_ready) begin
                req_ready = 1'b0;
                wait_cnt  = int'($urandom_range(0, 3));
            end else if (pend) begin
                if (wait_cnt == 0) rsp_valid = 1'b1;
                else wait_cnt--;
            end else if (req_valid && $urandom_range(0, 3) != 0) begin
                req_ready = 1'b1;
                pend = 1;
                if (nlog < MAXLOG) begin
                    log_reg[nlog] = req_reg;
                    log_wr[nlog]  = req_write;
                    log_wd[nlog]  = req_wdata;
                end
                rsp_rdata = $urandom;
                rsp_err   = (nlog == terr_txn);
                if (nlog != terr_txn) begin
                    if (req_write) begin
                        if (req_reg == 2'd1) ptr = int'(req_wdata);
                        else if (req_reg == 2'd2) begin
                            if (ptr < MAXN) sram[ptr] = req_wdata[7:0];
                            ptr++;
                        end
                    end else if (req_reg == 2'd2) begin
                        rsp_rdata = {24'h0, (ptr < MAXN) ? sram[ptr] : 8'h00};
                        if (ptr == range_idx) rsp_rdata[8] = 1'b1;
                        else if (ptr < MAXN && corrupt[ptr]) rsp_rdata[7:0] ^= 8'h5A;
                        ptr++;
                    end
                end
                nlog++;
            end
        end
    end

    task automatic clear_inj();
        for (int i = 0; i < MAXN; i++) corrupt[i] = 1'b0;
        range_idx = -1;
        terr_txn  = -1;
    endtask

    task automatic fill_rom();
        for (int i = 0; i < MAXN; i++) rom[i] = 8'($urandom);
    endtask

    // Expected transaction p of an n-byte run
    task automatic exp_txn(input int p, input int n, output logic [1:0] r,
                           output logic w, output logic [31:0] d, output string req);
        if (p == 0) begin r = 2'd0; w = 1; d = 32'h8C; req = "R1"; end
        else if (p == 1 || p == n + 2) begin r = 2'd1; w = 1; d = 0; req = "R2"; end
        else if (p <= n + 1) begin r = 2'd2; w = 1; d = {24'h0, rom[p-2]}; req = "R3"; end
        else if (p <= 2 * n + 2) begin r = 2'd2; w = 0; d = 0; req = "R4"; end
        else begin r = 2'd0; w = 1; d = 32'h10B; req = "R7"; end
    endtask

    task automatic expect_out(input int n, output int total, output int code, output int mm);
        int reads;
        reads = n; code = 0; mm = 0;
        for (int i = 0; i < n; i++) begin
            if (i == range_idx) begin reads = i + 1; code = 2; break; end
            if (corrupt[i]) begin
                mm++;
                if (mm == 5) begin reads = i + 1; code = 3; break; end
            end
        end
        if (code == 0 && mm > 0) code = 3;
        total = 3 + n + reads + ((code == 0) ? 1 : 0);
        if (terr_txn >= 0 && terr_txn < total) begin
            int rd;
            total = terr_txn + 1;
            code  = 1;
            rd    = terr_txn - (n + 3);
            if (rd < 0) rd = 0;
            mm = 0;
            for (int i = 0; i < rd; i++) if (corrupt[i]) mm++;
        end
    endtask

    task automatic run_case(input int n, input bit poke, input string tag);
        int total, code, mm, k, bad_at;
        logic [1:0] er; logic ew; logic [31:0] ed; string rq;
        nlog = 0; ptr = 0;
        img_len = LEN_W'(n);
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!(done || error) && k < 20000) begin
            @(negedge clk);
            k++;
            if (poke && k == 8) start = 1'b1;
            if (poke && k == 9) begin
                start = 1'b0;
                chk(busy == 1'b1, "R10", {tag, " busy after ignored start"}, busy, 1);
            end
        end
        chk(k < 20000, "R10", {tag, " completion"}, k, 20000);
        expect_out(n, total, code, mm);
        chk(done == (code == 0), (code == 0) ? "R7" : "R8", {tag, " done"}, done, code == 0);
        chk(error == (code != 0), (code == 2) ? "R5" : (code == 3) ? "R6" : "R8",
            {tag, " error"}, error, code != 0);
        chk(err_code == 2'(code), (code == 2) ? "R5" : (code == 3) ? "R6" : "R8",
            {tag, " err_code"}, err_code, code);
        chk(mism_cnt == 3'(mm), "R6", {tag, " mism_cnt"}, mism_cnt, mm);
        chk(busy == 1'b0, "R10", {tag, " busy at end"}, busy, 0);
        chk(nlog == total, (code == 1) ? "R8" : "R9", {tag, " transaction count"}, nlog, total);
        bad_at = -1;
        for (int p = 0; p < nlog && p < total && p < MAXLOG; p++) begin
            exp_txn(p, n, er, ew, ed, rq);
            if (bad_at < 0 && (log_reg[p] != er || log_wr[p] != ew || (ew && log_wd[p] != ed))) begin
                bad_at = p;
                $display("FAIL %s %s txn %0d: actual %0h/%0h/%0h expected %0h/%0h/%0h",
                         rq, tag, p, log_reg[p], log_wr[p], log_wd[p], er, ew, ed);
            end
        end
        n_checks++;
        if (bad_at >= 0) n_fail++;
        repeat (3) @(negedge clk);
        chk(done == (code == 0) && err_code == 2'(code), "R10", {tag, " status held"},
            err_code, code);
    endtask

    initial begin
        void'($urandom(32'd2024));
        clear_inj();
        fill_rom();
        nlog = 0; ptr = 0;
        repeat (4) @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0, "R11", "reset flags", {busy, done, error}, 0);
        chk(err_code == 0 && mism_cnt == 0, "R11", "reset code/count", {err_code, mism_cnt}, 0);
        chk(req_valid == 0, "R11", "reset req_valid", req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && req_valid == 0, "R11", "idle after reset", {busy, req_valid}, 0);

        run_case(0, 0, "R12 zero length");
        run_case(1, 0, "R7 single byte");
        fill_rom();
        run_case(6, 1, "R10 start while busy");
        clear_inj(); corrupt[1] = 1; corrupt[6] = 1;
        run_case(8, 0, "R6 two mismatches");
        clear_inj();
        corrupt[0] = 1; corrupt[2] = 1; corrupt[3] = 1; corrupt[5] = 1; corrupt[7] = 1; corrupt[9] = 1;
        run_case(10, 0, "R6 fifth mismatch stops");
        clear_inj(); corrupt[3] = 1; corrupt[4] = 1; corrupt[5] = 1; corrupt[6] = 1;
        run_case(7, 0, "R6 four mismatches at end");
        clear_inj(); corrupt[1] = 1; range_idx = 3;
        run_case(7, 0, "R5 range fault");
        clear_inj(); terr_txn = 0;
        run_case(5, 0, "R8 fault on halt");
        clear_inj(); terr_txn = 4;
        run_case(5, 0, "R8 fault in upload");
        clear_inj(); corrupt[2] = 1; terr_txn = 11;
        run_case(5, 0, "R8 fault in verify");
        clear_inj();
        run_case(4, 0, "R7 recovery");

        for (int t = 0; t < 14; t++) begin
            int n, mode;
            clear_inj();
            fill_rom();
            n = int'($urandom_range(1, 40));
            mode = int'($urandom_range(0, 4));
            if (mode == 1) corrupt[$urandom_range(0, n - 1)] = 1;
            if (mode == 2) for (int j = 0; j < 8; j++) corrupt[$urandom_range(0, n - 1)] = 1;
            if (mode == 3) range_idx = int'($urandom_range(0, n - 1));
            if (mode == 4) terr_txn = int'($urandom_range(0, 2 * n + 3));
            run_case(n, t == 5, "R4 random run");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule